// File: doc/BRIEF.md
# Time-Compare Event Trigger Unit

This block watches a synchronized 64-bit local time value, counted in nanoseconds, and compares it against a separate programmed start time on each of six channels. When an armed, enabled channel finds the time at or past its target, it raises an event flag for a fixed number of cycles. The flag then clears itself. The channel drives an event line whose active edge is rising or falling, as chosen per channel. A small routing stage turns the event of a chosen channel into a one-cycle start pulse for each of two downstream PWM timers, so a timer starts at a set time with no processor in the loop.

Software programs the unit through a simple write port. A target is written as two 32-bit halves. The upper half is only staged. Writing the lower half commits the whole 64-bit value and arms the channel. Each arm produces exactly one event. The time source, its rate correction and the PWM timers themselves are outside this block.

Top module: `tcmp_event_unit`

## Requirements
- R1: After reset every event flag, event line and timer start output is 0. Every channel is disarmed and disabled, with rising polarity. Both routes are disabled.
- R2: Write addressing is wr_addr[4:2] = channel and wr_addr[1:0] = register. Register 0 stages the upper 32 target bits and has no effect on the compare. Register 1 loads the lower 32 bits, commits {staged upper, data} as the target and arms the channel.
- R3: An armed, enabled channel fires when local_time is greater than or equal to its target. This includes a time value that jumps past the target. The flag rises on the clock edge after the cycle in which the condition holds.
- R4: Once raised, a channel's flag stays high for FLAG_LEN cycles (default 3) and then clears without any write.
- R5: A channel that has fired is disarmed and gives no further event until its lower target half is written or it is re-enabled.
- R6: Register 2 of a channel holds bit 0 = enable and bit 1 = polarity (0 rising, 1 falling). The event line equals the flag for rising polarity and the inverted flag for falling polarity.
- R7: A disabled channel never fires. Writing register 2 with bit 0 set re-arms the channel against its stored target.
- R8: Address 0x1C+k (k = 0, 1) sets route k: bits [2:0] select the source channel and bit 3 enables the route. Timer start k pulses for exactly one cycle, in the first cycle of the source channel's flag, regardless of that channel's polarity. No pulse occurs when the route is disabled or selects channel 6 or 7.
- R9: A lower-half or control write to a channel in the same cycle as its match suppresses that match. The written state governs from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address: channel and register select |
| wr_data | input | 32 | Write data |
| local_time | input | 64 | Synchronized local time in nanoseconds |
| evt_line | output | 6 | Per-channel event line with selected active edge |
| evt_flag | output | 6 | Per-channel self-clearing event flag |
| tmr_start | output | 2 | One-cycle start pulse for each routed timer |

## Verification
The bench goes after a time step that leaps over a target. A design that tests only for equality would never fire on it. It also checks that a staged upper half stays out of the compare; committing it early would fire against a half-written target. Further cases are a match that coincides with a rewrite, which a design giving the compare priority would let fire against stale state, and a channel left armed after firing, which would repeat its event every cycle. Routes are checked with a falling-polarity source and a disabled route, and the flag length is counted in cycles, so a start pulse that depends on polarity or a flag that never clears shows up as a mismatch.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  parameter int TCMP_NCH      = 6;
  parameter int TCMP_NTMR     = 2;
  parameter int TCMP_TW       = 64;
  parameter int TCMP_RW       = 32;
  parameter int TCMP_FLAG_LEN = 3;

  // per-channel register select in wr_addr[1:0]
  typedef enum logic [1:0] {
    SEL_TGT_HI = 2'd0,
    SEL_TGT_LO = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } tcmp_sel_e;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_POL_BIT = 1;
endpackage

// File: rtl/tcmp_rst_sync.sv
module tcmp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_out = s2_q;
endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
  import tcmp_pkg::*;
#(
  parameter int TW       = 64,
  parameter int RW       = 32,
  parameter int FLAG_LEN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic          wr_ctl,
  input  logic [RW-1:0] wr_data,
  input  logic [TW-1:0] local_time,
  output logic          evt_flag,
  output logic          evt_line
);
  localparam int HW = TW - RW;
  localparam int CW = $clog2(FLAG_LEN + 1);

  logic [HW-1:0] hi_q, hi_d;
  logic [TW-1:0] tgt_q, tgt_d;
  logic          arm_q, arm_d;
  logic          en_q, en_d;
  logic          pol_q, pol_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;
  logic          reached, wr_any, hit;

  // next-state logic
  always_comb begin
    reached = (local_time >= tgt_q);
    wr_any  = wr_lo | wr_ctl;
    hit     = arm_q & en_q & reached & ~wr_any;

    hi_d  = wr_data[HW-1:0];
    tgt_d = {hi_q, wr_data};
    en_d  = wr_data[CTL_EN_BIT];
    pol_d = wr_data[CTL_POL_BIT];

    if (wr_lo || (wr_ctl && wr_data[CTL_EN_BIT]))
      arm_d = 1'b1;
    else if (hit)
      arm_d = 1'b0;
    else
      arm_d = arm_q;

    cnt_ce = hit | (cnt_q != '0);
    if (hit)
      cnt_d = CW'(FLAG_LEN);
    else
      cnt_d = cnt_q - CW'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      tgt_q <= '0;
      arm_q <= 1'b0;
      en_q  <= 1'b0;
      pol_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (wr_hi)  hi_q  <= hi_d;
      if (wr_lo)  tgt_q <= tgt_d;
      if (wr_ctl) begin
        en_q  <= en_d;
        pol_q <= pol_d;
      end
      arm_q <= arm_d;
      if (cnt_ce) cnt_q <= cnt_d;
    end
  end

  assign evt_flag = (cnt_q != '0);
  assign evt_line = evt_flag ^ pol_q;

  // a raised flag must trace back to the time having reached the target
  p_fire_reached_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> $past(reached));

  // a channel that was disabled cannot raise its flag
  p_fire_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> $past(en_q));

  // a rewrite in the matching cycle wins over the match
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_lo | wr_ctl) |-> !$rose(evt_flag));

  // the hold counter never exceeds the programmed flag length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FLAG_LEN));

  // after firing the channel is no longer armed
  p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> !arm_q || $past(wr_any));

  generate
    if (FLAG_LEN > 1) begin : g_hold
      p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flag) |=> evt_flag);
    end
  endgenerate
endmodule

// File: rtl/tcmp_router.sv
module tcmp_router #(
  parameter int NCH  = 6,
  parameter int NTMR = 2,
  parameter int SW   = 3,
  parameter int RW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  evt_flag,
  input  logic [NTMR-1:0] wr_route,
  input  logic [RW-1:0]   wr_data,
  output logic [NTMR-1:0] tmr_start
);
  localparam int NSRC = 1 << SW;

  logic [NCH-1:0]  prev_q;
  logic [NCH-1:0]  rise;
  logic [NSRC-1:0] rise_ext;

  always_comb begin
    rise     = evt_flag & ~prev_q;
    rise_ext = '0;
    rise_ext[NCH-1:0] = rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= evt_flag;
  end

  genvar k;
  generate
    for (k = 0; k < NTMR; k++) begin : g_tmr
      logic [SW-1:0] src_q, src_d;
      logic          ren_q, ren_d;

      always_comb begin
        src_d = wr_data[SW-1:0];
        ren_d = wr_data[SW];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          src_q <= '0;
          ren_q <= 1'b0;
        end else if (wr_route[k]) begin
          src_q <= src_d;
          ren_q <= ren_d;
        end
      end

      assign tmr_start[k] = ren_q & rise_ext[src_q];

      // the start output is a single-cycle pulse
      p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start[k] && !wr_route[k] |=> !tmr_start[k]);

      // a start pulse only accompanies a raised event flag
      p_start_has_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start[k] |-> |evt_flag);
    end
  endgenerate
endmodule

// File: rtl/tcmp_event_unit.sv
module tcmp_event_unit
  import tcmp_pkg::*;
#(
  parameter int NCH      = TCMP_NCH,
  parameter int NTMR     = TCMP_NTMR,
  parameter int TW       = TCMP_TW,
  parameter int RW       = TCMP_RW,
  parameter int FLAG_LEN = TCMP_FLAG_LEN,
  localparam int CIW     = $clog2(NCH + 1),
  localparam int AW      = CIW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [RW-1:0]   wr_data,
  input  logic [TW-1:0]   local_time,
  output logic [NCH-1:0]  evt_line,
  output logic [NCH-1:0]  evt_flag,
  output logic [NTMR-1:0] tmr_start
);
  logic           rst_sync_n;
  logic [CIW-1:0] ch_idx;
  tcmp_sel_e      sel;
  logic [NCH-1:0] wr_hi, wr_lo, wr_ctl;
  logic [NTMR-1:0] wr_route;

  tcmp_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  always_comb begin
    ch_idx = wr_addr[AW-1:2];
    sel    = tcmp_sel_e'(wr_addr[1:0]);
  end

  genvar c, k;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      assign wr_hi[c]  = wr_en && (ch_idx == CIW'(c)) && (sel == SEL_TGT_HI);
      assign wr_lo[c]  = wr_en && (ch_idx == CIW'(c)) && (sel == SEL_TGT_LO);
      assign wr_ctl[c] = wr_en && (ch_idx == CIW'(c)) && (sel == SEL_CTRL);

      tcmp_channel #(
        .TW       (TW),
        .RW       (RW),
        .FLAG_LEN (FLAG_LEN)
      ) u_ch (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .wr_hi      (wr_hi[c]),
        .wr_lo      (wr_lo[c]),
        .wr_ctl     (wr_ctl[c]),
        .wr_data    (wr_data),
        .local_time (local_time),
        .evt_flag   (evt_flag[c]),
        .evt_line   (evt_line[c])
      );
    end

    for (k = 0; k < NTMR; k++) begin : g_rt
      assign wr_route[k] = wr_en && (ch_idx == {CIW{1'b1}}) && (wr_addr[1:0] == 2'(k));
    end
  endgenerate

  tcmp_router #(
    .NCH  (NCH),
    .NTMR (NTMR),
    .SW   (CIW),
    .RW   (RW)
  ) u_route (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .evt_flag  (evt_flag),
    .wr_route  (wr_route),
    .wr_data   (wr_data),
    .tmr_start (tmr_start)
  );

  // at most one register is addressed by any write
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({wr_hi, wr_lo, wr_ctl, wr_route}) <= 1);
endmodule

// File: tb/tcmp_event_unit_bench.sv
module tcmp_event_unit_bench;
  import tcmp_pkg::*;

  localparam int NC = 6;
  localparam int NT = 2;
  localparam int FL = TCMP_FLAG_LEN;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [63:0] local_time;
  logic [63:0] jump;
  logic [5:0]  evt_line, evt_flag;
  logic [1:0]  tmr_start;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  tcmp_event_unit u_tcmp_event_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .local_time (local_time),
    .evt_line   (evt_line),
    .evt_flag   (evt_flag),
    .tmr_start  (tmr_start)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [63:0] m_tgt [NC];
  logic [31:0] m_hi  [NC];
  bit m_arm [NC], m_en [NC], m_pol [NC], m_prev [NC];
  int m_cnt [NC];
  int m_src [NT];
  bit m_ren [NT];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_tgt[c] = '0; m_hi[c] = '0; m_arm[c] = 0; m_en[c] = 0;
        m_pol[c] = 0; m_prev[c] = 0; m_cnt[c] = 0;
      end
      for (int k = 0; k < NT; k++) begin m_src[k] = 0; m_ren[k] = 0; end
    end else begin
      for (int c = 0; c < NC; c++) begin
        bit wlo, wct, fire;
        wlo = wr_en && (wr_addr[4:2] == c) && (wr_addr[1:0] == 1);
        wct = wr_en && (wr_addr[4:2] == c) && (wr_addr[1:0] == 2);
        m_prev[c] = (m_cnt[c] != 0);
        fire = m_arm[c] && m_en[c] && (local_time >= m_tgt[c]) && !wlo && !wct;
        if (fire) begin m_cnt[c] = FL; m_arm[c] = 0; end
        else if (m_cnt[c] > 0) m_cnt[c]--;
      end
      if (wr_en) begin
        int ch, sl;
        ch = int'(wr_addr[4:2]);
        sl = int'(wr_addr[1:0]);
        if (ch < NC) begin
          if (sl == 0) m_hi[ch] = wr_data;
          else if (sl == 1) begin m_tgt[ch] = {m_hi[ch], wr_data}; m_arm[ch] = 1; end
          else if (sl == 2) begin
            m_en[ch] = wr_data[0]; m_pol[ch] = wr_data[1];
            if (wr_data[0]) m_arm[ch] = 1;
          end
        end else if (ch == 7 && sl < NT) begin
          m_src[sl] = int'(wr_data[2:0]);
          m_ren[sl] = wr_data[3];
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [5:0] ef, el;
      logic [1:0] es;
      for (int c = 0; c < NC; c++) begin
        ef[c] = (m_cnt[c] != 0);
        el[c] = ef[c] ^ m_pol[c];
      end
      for (int k = 0; k < NT; k++)
        es[k] = m_ren[k] && (m_src[k] < NC) && (m_cnt[m_src[k] % NC] != 0) && !m_prev[m_src[k] % NC];
      chk(evt_flag == ef, "R4", "flag vector", longint'(evt_flag), longint'(ef));
      chk(evt_line == el, "R6", "line vector", longint'(evt_line), longint'(el));
      chk(tmr_start == es, "R8", "start vector", longint'(tmr_start), longint'(es));
    end
  end

  // event and pulse counters seen at the ports
  int ev_cnt [NC];
  int hi_cyc [NC];
  int st_cnt [NT];
  bit mon_prev [NC];
  initial begin
    for (int c = 0; c < NC; c++) begin ev_cnt[c] = 0; hi_cyc[c] = 0; mon_prev[c] = 0; end
    for (int k = 0; k < NT; k++) st_cnt[k] = 0;
  end
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NC; c++) begin
        if (evt_flag[c] && !mon_prev[c]) ev_cnt[c]++;
        if (evt_flag[c]) hi_cyc[c]++;
        mon_prev[c] = evt_flag[c];
      end
      for (int k = 0; k < NT; k++) if (tmr_start[k]) st_cnt[k]++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(negedge clk);
    local_time = local_time + 64'd20 + jump;
    jump = '0;
  endtask

  task automatic wr(input int c, input int s, input logic [31:0] d);
    wr_en   = 1'b1;
    wr_addr = {c[2:0], s[1:0]};
    wr_data = d;
    tick();
    wr_en   = 1'b0;
  endtask

  initial begin
    logic [31:0] t0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    local_time = 64'd0; jump = '0;
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    chk(evt_flag == 0, "R1", "flags after reset", longint'(evt_flag), 0);
    chk(evt_line == 0, "R1", "lines after reset", longint'(evt_line), 0);
    chk(tmr_start == 0, "R1", "starts after reset", longint'(tmr_start), 0);

    // routes: timer0 <- ch1, timer1 <- ch4
    wr(7, 0, 32'h9);
    wr(7, 1, 32'hC);
    t0 = local_time[31:0];
    wr(0, 0, 0); wr(0, 1, t0 + 400);  wr(0, 2, 1);
    wr(1, 0, 0); wr(1, 1, t0 + 600);  wr(1, 2, 3);
    wr(4, 0, 0); wr(4, 1, t0 + 800);  wr(4, 2, 1);
    wr(2, 0, 0); wr(2, 1, t0 + 300);  wr(2, 2, 0);
    wr(3, 0, 0); wr(3, 1, t0 + 5000); wr(3, 2, 1);
    repeat (50) tick();
    jump = 64'd6000;               // step correction leaps over ch3 target
    repeat (10) tick();

    chk(ev_cnt[0] == 1, "R3", "ch0 events", ev_cnt[0], 1);
    chk(ev_cnt[1] == 1, "R6", "ch1 falling events", ev_cnt[1], 1);
    chk(ev_cnt[3] == 1, "R3", "ch3 step-over events", ev_cnt[3], 1);
    chk(ev_cnt[4] == 1, "R3", "ch4 events", ev_cnt[4], 1);
    chk(ev_cnt[2] == 0, "R7", "disabled ch2 events", ev_cnt[2], 0);
    chk(hi_cyc[0] == FL, "R4", "ch0 flag cycles", hi_cyc[0], FL);
    chk(evt_line[1] == 1'b1, "R6", "ch1 idle level", longint'(evt_line[1]), 1);
    chk(st_cnt[0] == 1, "R8", "timer0 starts", st_cnt[0], 1);
    chk(st_cnt[1] == 1, "R8", "timer1 starts", st_cnt[1], 1);

    repeat (20) tick();
    chk(ev_cnt[0] == 1, "R5", "ch0 one shot", ev_cnt[0], 1);

    // staged upper half must not reach the compare
    wr(0, 0, 1); wr(0, 1, 0);      // far future target, armed
    wr(0, 0, 0);                   // staged only
    repeat (5) tick();
    chk(ev_cnt[0] == 1, "R2", "upper staged only", ev_cnt[0], 1);
    wr(0, 1, 100);                 // commit past target
    repeat (5) tick();
    chk(ev_cnt[0] == 2, "R2", "lower commit fires", ev_cnt[0], 2);
    chk(st_cnt[0] == 1, "R8", "unrouted ch0 gives no start", st_cnt[0], 1);

    // re-enable re-arms
    wr(2, 2, 1);
    repeat (5) tick();
    chk(ev_cnt[2] == 1, "R7", "re-enable fires", ev_cnt[2], 1);

    // disabled route
    wr(7, 0, 32'h1);
    wr(1, 2, 3);
    repeat (6) tick();
    chk(ev_cnt[1] == 2, "R7", "ch1 re-armed", ev_cnt[1], 2);
    chk(st_cnt[0] == 1, "R8", "disabled route", st_cnt[0], 1);

    // write in the match cycle wins
    t0 = local_time[31:0];
    wr(5, 0, 0); wr(5, 1, t0 + 80); wr(5, 2, 1);
    tick();
    wr(5, 1, t0 + 100000);         // lands in the cycle time == target
    repeat (20) tick();
    chk(ev_cnt[5] == 0, "R9", "match suppressed by write", ev_cnt[5], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule